// File: doc/BRIEF.md
# Bus-Master Request Arbiter for Shared System Memory

This block lets an on-chip engine become master of a system RAM that it shares with a host processor. The host makes the arbitration decision; the block only asks for the bus, waits to be granted it, announces ownership and then runs plain memory cycles. When the engine presents an access, the block raises a request toward the host. Once the host's grant has been seen on two consecutive clock edges, the block pulls its active-low acknowledge down. It then drives a 16-bit word address (a 64K-word space) together with read and write strobes, and drives write data where needed. On the host side, an external page register supplies any address bits above bit 15 while acknowledge is low.

The chip's pads sit outside the block. For this reason every bus output comes with its own output enable, and the pad ring turns that enable into a high-impedance driver. No external isolation buffers are then needed. When the engine keeps further accesses pending, they are served back to back in one bus tenure, up to a parameter limit. After that the bus is handed back and a fresh request is made.

Top module: `dma_bus_arbiter`

## Requirements
- R1: During and right after reset, busReq is 0, busAckN is 1, accDone is 0 and both output enables (memCtlOe, memDataOe) are 0.
- R2: With the block idle, accReq sampled high at a clock edge makes busReq 1 from that edge on.
- R3: busAckN falls only after busGrant has been sampled high on two consecutive edges while requesting. It falls at the second of those edges. The bus enables stay 0 until then.
- R4: If busGrant is sampled low on the edge after it was first seen high, the block goes back to requesting. busReq stays 1, busAckN stays 1 and nothing is driven.
- R5: memCtlOe is 1 exactly when busAckN is 0, and busReq is 1 whenever busAckN is 0.
- R6: Each access asserts one strobe (memRdN for a read, memWrN for a write, active low, never both) for exactly CYCLE_CLKS cycles. memAddr stays steady throughout. A write drives accWData with memDataOe = 1, and memDataOe is never 1 while memRdN is low.
- R7: accDone is a one-cycle pulse in the cycle after the strobe ends. For a read, accRData then holds the word memDataIn carried at the last strobe edge.
- R8: If accReq is high in the second cycle after accDone, the next access starts in the same tenure with busAckN still low. A tenure holds at most MAX_BURST accesses.
- R9: After a tenure's last access, busAckN rises, busReq falls and both enables drop, all at the same edge, two cycles after accDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accReq | input | 1 | Engine has an access pending (held until accDone) |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | ADDR_W | Word address of the access |
| accWData | input | DATA_W | Write data |
| accDone | output | 1 | One-cycle pulse: access finished |
| accRData | output | DATA_W | Read data, valid from accDone |
| busReq | output | 1 | Bus request to host, active high |
| busGrant | input | 1 | Bus grant from host, active high |
| busAckN | output | 1 | Bus ownership acknowledge, active low |
| memAddr | output | ADDR_W | Memory word address |
| memDataOut | output | DATA_W | Write data toward memory |
| memDataIn | input | DATA_W | Read data from memory |
| memDataOe | output | 1 | Enable for the data bus drivers |
| memCtlOe | output | 1 | Enable for the address and strobe drivers |
| memRdN | output | 1 | Read strobe, active low |
| memWrN | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with CYCLE_CLKS = 3 and MAX_BURST = 2. A three-clock strobe shows whether the cycle counter really stretches the strobe past a single edge. A burst limit of two means a six-access run must split into exactly three tenures, so both the cap and the release-then-re-request path are exercised. With a single grant pulse and then a steady grant, the bench also exercises the withdrawn-grant fall-back and the exact two-edge latency to acknowledge.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_GNT,
    ST_CYC,
    ST_GAP,
    ST_HOLD,
    ST_REL
  } arbState_e;

  typedef struct packed {
    logic loadAcc;
    logic captureRd;
    logic driveCtl;
    logic driveData;
    logic rdStrobe;
    logic wrStrobe;
  } dpCtl_t;

endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int CYCLE_CLKS = 2,
  parameter int MAX_BURST  = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   accReq,
  input  logic   accWrite,
  input  logic   busGrant,
  output logic   busReq,
  output logic   busAckN,
  output logic   accDone,
  output dpCtl_t dpCtl
);

  localparam int CNT_W   = $clog2(CYCLE_CLKS + 1);
  localparam int BURST_W = $clog2(MAX_BURST + 1);
  localparam logic [CNT_W-1:0]   LAST_CNT  = CNT_W'(CYCLE_CLKS - 1);
  localparam logic [BURST_W-1:0] BURST_CAP = BURST_W'(MAX_BURST);

  arbState_e           state, nextState;
  logic [CNT_W-1:0]    cycCnt;
  logic [BURST_W-1:0]  burstCnt;
  logic                curWrite;
  logic                startFirst, startNext, lastClk;

  always_comb begin
    startFirst = (state == ST_GNT) && busGrant;
    startNext  = (state == ST_HOLD) && accReq && (burstCnt < BURST_CAP);
    lastClk    = (state == ST_CYC) && (cycCnt == LAST_CNT);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (accReq) nextState = ST_REQ;
      ST_REQ:  if (busGrant) nextState = ST_GNT;
      ST_GNT:  nextState = busGrant ? ST_CYC : ST_REQ;
      ST_CYC:  if (lastClk) nextState = ST_GAP;
      ST_GAP:  nextState = ST_HOLD;
      ST_HOLD: nextState = startNext ? ST_CYC : ST_REL;
      ST_REL:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cycCnt   <= '0;
      burstCnt <= '0;
      curWrite <= 1'b0;
    end else begin
      state <= nextState;
      if (startFirst || startNext) begin
        cycCnt   <= '0;
        curWrite <= accWrite;
      end else if (state == ST_CYC) begin
        cycCnt <= cycCnt + 1'b1;
      end
      if (startFirst) begin
        burstCnt <= BURST_W'(1);
      end else if (startNext) begin
        burstCnt <= burstCnt + 1'b1;
      end
    end
  end

  logic owning;
  always_comb begin
    owning   = (state == ST_CYC) || (state == ST_GAP) || (state == ST_HOLD);
    busReq   = (state != ST_IDLE) && (state != ST_REL);
    busAckN  = !owning;
    accDone  = (state == ST_GAP);

    dpCtl.loadAcc   = startFirst || startNext;
    dpCtl.captureRd = lastClk && !curWrite;
    dpCtl.driveCtl  = owning;
    dpCtl.driveData = curWrite && ((state == ST_CYC) || (state == ST_GAP));
    dpCtl.rdStrobe  = (state == ST_CYC) && !curWrite;
    dpCtl.wrStrobe  = (state == ST_CYC) && curWrite;
  end

endmodule

// File: rtl/dma_arb_dp.sv
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWData,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memCtlOe,
  output logic              memRdN,
  output logic              memWrN,
  output logic [DATA_W-1:0] accRData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
    end else begin
      if (dpCtl.loadAcc) begin
        addrReg  <= accAddr;
        wdataReg <= accWData;
      end
      if (dpCtl.captureRd) begin
        rdataReg <= memDataIn;
      end
    end
  end

  always_comb begin
    memAddr    = addrReg;
    memDataOut = wdataReg;
    memDataOe  = dpCtl.driveData;
    memCtlOe   = dpCtl.driveCtl;
    memRdN     = !dpCtl.rdStrobe;
    memWrN     = !dpCtl.wrStrobe;
    accRData   = rdataReg;
  end

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 2,
  parameter int MAX_BURST  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accReq,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWData,
  output logic              accDone,
  output logic [DATA_W-1:0] accRData,
  output logic              busReq,
  input  logic              busGrant,
  output logic              busAckN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memDataOe,
  output logic              memCtlOe,
  output logic              memRdN,
  output logic              memWrN
);

  dpCtl_t dpCtl;

  dma_arb_ctrl #(
    .CYCLE_CLKS(CYCLE_CLKS),
    .MAX_BURST (MAX_BURST)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .accReq  (accReq),
    .accWrite(accWrite),
    .busGrant(busGrant),
    .busReq  (busReq),
    .busAckN (busAckN),
    .accDone (accDone),
    .dpCtl   (dpCtl)
  );

  dma_arb_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .accAddr   (accAddr),
    .accWData  (accWData),
    .memDataIn (memDataIn),
    .memAddr   (memAddr),
    .memDataOut(memDataOut),
    .memDataOe (memDataOe),
    .memCtlOe  (memCtlOe),
    .memRdN    (memRdN),
    .memWrN    (memWrN),
    .accRData  (accRData)
  );

endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGrant,
  input logic              busAckN,
  input logic              memCtlOe,
  input logic              memDataOe,
  input logic              memRdN,
  input logic              memWrN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              accDone
);

  AST_OE_MATCHES_ACK: assert property (@(posedge clk) disable iff (!rstN)
    memCtlOe == !busAckN); // R5

  AST_ACK_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busAckN |-> busReq); // R5

  AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAckN) |-> ($past(busGrant) && busReq)); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!memRdN && !memWrN)); // R6

  AST_NO_DATA_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> (memCtlOe && memRdN)); // R6

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    ((!memRdN || !memWrN) && $past(!memRdN || !memWrN)) |-> $stable(memAddr)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    accDone |=> !accDone); // R7

  AST_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAckN) |-> (!busReq && !memCtlOe && !memDataOe)); // R9

endmodule

bind dma_bus_arbiter dma_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busGrant (busGrant),
  .busAckN  (busAckN),
  .memCtlOe (memCtlOe),
  .memDataOe(memDataOe),
  .memRdN   (memRdN),
  .memWrN   (memWrN),
  .memAddr  (memAddr),
  .accDone  (accDone)
);

// File: tb/dma_bus_arbiter_tb.sv
`timescale 1ns/1ps
module dma_bus_arbiter_tb;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CYC    = 3;
  localparam int BURST  = 2;
  localparam int NVEC   = 6;

  // {write, address, data (write data or expected read data)}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 16'h0010, 16'hA5C3},
    {1'b1, 16'hFFFF, 16'h1234},
    {1'b1, 16'h0000, 16'hBEEF},
    {1'b0, 16'h0010, 16'hA5C3},
    {1'b0, 16'hFFFF, 16'h1234},
    {1'b0, 16'h0000, 16'hBEEF}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accReq = 1'b0;
  logic              accWrite = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic [DATA_W-1:0] accWData = '0;
  logic              accDone;
  logic [DATA_W-1:0] accRData;
  logic              busReq;
  logic              busGrant;
  logic              busAckN;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memDataOut;
  logic [DATA_W-1:0] memDataIn = '0;
  logic              memDataOe, memCtlOe, memRdN, memWrN;

  logic hostAuto = 1'b0;
  logic grantAuto = 1'b0;
  logic grantManual = 1'b0;
  assign busGrant = hostAuto ? grantAuto : grantManual;

  always #2.5 clk = ~clk;

  dma_bus_arbiter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_CLKS(CYC), .MAX_BURST(BURST)
  ) u_dut (
    .clk(clk), .rstN(rstN), .accReq(accReq), .accWrite(accWrite),
    .accAddr(accAddr), .accWData(accWData), .accDone(accDone),
    .accRData(accRData), .busReq(busReq), .busGrant(busGrant),
    .busAckN(busAckN), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataIn(memDataIn), .memDataOe(memDataOe), .memCtlOe(memCtlOe),
    .memRdN(memRdN), .memWrN(memWrN)
  );

  int nChecks = 0, nFails = 0;
  int monChecks = 0, monFails = 0;
  int tenures = 0;
  int strobeRun = 0;
  logic prevAckN = 1'b1;
  logic [DATA_W-1:0] mem [256];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // host grant follower, memory model and bus monitor
  always @(negedge clk) begin
    grantAuto <= busReq;
    if (rstN) begin
      monChecks++;
      if (memCtlOe != !busAckN) begin // R5
        monFails++;
        $display("FAIL R5 oe/ack actual=%0b expected=%0b", memCtlOe, !busAckN);
      end
      if (!busAckN && prevAckN) tenures++;
      prevAckN = busAckN;
      if (!memRdN) memDataIn <= mem[memAddr[7:0]];
      if (!memWrN) begin
        monChecks++;
        if (!memDataOe || memDataOut != accWData) begin // R6
          monFails++;
          $display("FAIL R6 write data actual=%0h expected=%0h", memDataOut, accWData);
        end
        mem[memAddr[7:0]] = memDataOut;
      end
      if (!memRdN || !memWrN) begin
        strobeRun++;
        monChecks++;
        if (memAddr != accAddr) begin // R6
          monFails++;
          $display("FAIL R6 address actual=%0h expected=%0h", memAddr, accAddr);
        end
      end else if (strobeRun != 0) begin
        monChecks++;
        if (strobeRun != CYC) begin // R6
          monFails++;
          $display("FAIL R6 strobe length actual=%0d expected=%0d", strobeRun, CYC);
        end
        strobeRun = 0;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==",
             nChecks + monChecks + 1, nFails + monFails + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busReq == 0 && busAckN == 1 && accDone == 0, "R1 handshake", {busReq, busAckN}, 2'b01);
    check(memCtlOe == 0 && memDataOe == 0, "R1 enables", {memCtlOe, memDataOe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busReq == 0 && busAckN == 1, "R1 after release", {busReq, busAckN}, 2'b01);

    // vector table: host grants automatically, engine keeps accesses pending
    hostAuto = 1'b1;
    accReq = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      accWrite = VEC[i][32];
      accAddr  = VEC[i][31:16];
      accWData = VEC[i][15:0];
      do @(negedge clk); while (!accDone);
      if (!VEC[i][32])
        check(accRData == VEC[i][15:0], "R7 read data", accRData, VEC[i][15:0]);
      if (i == NVEC - 1) accReq = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(tenures == NVEC / BURST, "R8 tenures per burst cap", tenures, NVEC / BURST);
    check(busReq == 0 && busAckN == 1 && memCtlOe == 0, "R9 idle after run",
          {busReq, busAckN, memCtlOe}, 3'b010);

    // directed: request latency, withdrawn grant, acknowledge latency
    hostAuto = 1'b0;
    grantManual = 1'b0;
    @(negedge clk);
    accWrite = 1'b0;
    accAddr  = 16'hFFFF;
    accReq   = 1'b1;
    @(negedge clk);
    check(busReq == 1, "R2 request raised", busReq, 1);
    check(busAckN == 1 && memCtlOe == 0, "R3 no drive before grant", {busAckN, memCtlOe}, 2'b10);
    grantManual = 1'b1;
    @(negedge clk);
    grantManual = 1'b0;
    check(busAckN == 1 && memCtlOe == 0, "R3 one grant edge only", {busAckN, memCtlOe}, 2'b10);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(busReq == 1 && busAckN == 1 && memCtlOe == 0 && memDataOe == 0,
            "R4 withdrawn grant", {busReq, busAckN, memCtlOe, memDataOe}, 4'b1100);
    end
    grantManual = 1'b1;
    @(negedge clk);
    check(busAckN == 1, "R3 ack after first grant edge", busAckN, 1);
    @(negedge clk);
    check(busAckN == 0 && memCtlOe == 1, "R3 ack at second grant edge", {busAckN, memCtlOe}, 2'b01);
    do @(negedge clk); while (!accDone);
    check(accRData == 16'h1234, "R7 directed read", accRData, 16'h1234);
    accReq = 1'b0;
    @(negedge clk);
    check(busAckN == 0 && busReq == 1, "R8 held one cycle after done", {busAckN, busReq}, 2'b01);
    @(negedge clk);
    check(busAckN == 1 && busReq == 0 && memCtlOe == 0, "R9 release together",
          {busAckN, busReq, memCtlOe}, 3'b100);
    grantManual = 1'b0;
    repeat (3) @(negedge clk);
    check(busReq == 0 && busAckN == 1, "R2 stays idle without access", {busReq, busAckN}, 2'b01);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks + monChecks, nFails + monFails);
    $finish;
  end

endmodule